// File: doc/BRIEF.md
# Four-Level Nested Address Translation Walker

This block converts a 64-bit guest-physical address into a host-physical address. It walks a radix tree of 512-entry tables held in memory. The walk has four levels, and each level is indexed by a 9-bit slice of the input address. The first table's physical address comes from a root register, which is captured when translation is switched on. Each 64-bit entry is fetched over a single-outstanding request/response port. The walker checks the entry's read, write and execute permissions against the access type of the request. It either descends to the next level, finishes at a leaf, or stops with a violation that names the level where the walk failed.

Large mappings are supported. When an entry has its super-page bit set, the walk ends at that level and the unused index bits become part of the page offset. When translation is disabled, the input address passes through unchanged.

The block handles one translation at a time. While a walk is in flight, `busy_o` is high and new requests are ignored. The result appears as a single-cycle strobe.

Top module: `gpw_walker`

## Requirements
- R1: The input address is split into level-4 index bits 47:39, level-3 index bits 38:30, level-2 index bits 29:21, level-1 index bits 20:12 and offset bits 11:0. Each entry is read at the address {table_base[51:12], index, 3'b000}. A walk that reaches level 1 performs four reads and returns {entry[51:12], addr[11:0]}.
- R2: With translation enabled, a request whose address bits 63:48 are not all zero ends with a fault at level 0 and issues no memory read.
- R3: The root table base is taken from `root_base_i` (bits 51:12, low 12 bits forced to zero) on the cycle `xlat_en_i` goes from 0 to 1. Later changes to `root_base_i` have no effect until the next such rise.
- R4: Entry layout: bit 0 grants read, bit 1 grants write, bit 2 grants execute, bit 7 marks a super page, and bits 51:12 give the next table base or frame. The low 12 bits of a next-table base are zero.
- R5: A super page at level 3 returns {entry[51:30], addr[29:0]} after two reads. A super page at level 2 returns {entry[51:21], addr[20:0]} after three reads.
- R6: A super-page bit set in a level-4 entry is a violation reported at level 4.
- R7: Access types are encoded as 2'b00 read, 2'b01 write, 2'b10 execute, and 2'b11 is treated as read. If the permission bit needed for the access type is clear at any level, the walk stops at that level with a fault and no further reads are made.
- R8: An entry with bits 2:0 all zero is not present. The walk faults at that level.
- R9: With `xlat_en_i` low, the result returns the input address unchanged, including bits 63:48. There is no fault and no memory read.
- R10: `busy_o` is high from the cycle after a request is accepted until the result has been delivered. Requests made while busy are dropped. `res_valid_o` is high for exactly one cycle, and `res_level_o` is 0 on success.
- R11: `mem_req_o` is a one-cycle pulse per entry read. The walker waits any number of cycles for `mem_rvalid_i` before it uses `mem_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_en_i | input | 1 | Translation enable; its rising edge loads the root register |
| root_base_i | input | 64 | Physical base of the top-level table |
| req_valid_i | input | 1 | Translation request strobe |
| req_addr_i | input | 64 | Guest-physical address to translate |
| req_acc_i | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 read |
| busy_o | output | 1 | A walk is in progress; requests are ignored |
| mem_req_o | output | 1 | Entry read request pulse |
| mem_addr_o | output | 64 | Entry address for the read |
| mem_rvalid_i | input | 1 | Entry read data valid |
| mem_rdata_i | input | 64 | Entry read data |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_addr_o | output | 64 | Host-physical address; meaningful when no fault |
| res_fault_o | output | 1 | Translation violation |
| res_level_o | output | 3 | Level that faulted (4..1), or 0 |

## Verification
The hardest cases to reach are faults partway down the tree: a missing permission, an entry that is not present, or a reserved super-page bit at one specific level, combined with a given access type. These are hard because they depend on the contents of tables that the walker reaches only after earlier reads. The bench builds a fresh chain of tables for every address before issuing it. It chooses the level at which a super page or a damaged permission field is placed, and the memory model answers each read after a random delay. The bench then compares the result address, the fault, the reported level and the number of reads against its own walk of the same array. A request issued while a walk is in flight, and a root change made while translation stays enabled, are driven as directed cases.

// File: rtl/gpw_pkg.sv
package gpw_pkg;
  localparam logic [1:0] ACC_RD = 2'b00;
  localparam logic [1:0] ACC_WR = 2'b01;
  localparam logic [1:0] ACC_EX = 2'b10;

  localparam int BIT_R  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_X  = 2;
  localparam int BIT_SP = 7;

  typedef enum logic [1:0] {EV_NEXT, EV_LEAF, EV_FAULT} ev_e;
endpackage

// File: rtl/gpw_idx.sv
module gpw_idx #(
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int PA_W  = 52,
  parameter int LVL_W = 3
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [63:0]      va_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [63:0]      ent_addr_o
);
  localparam int ENT_B = OFF_W - IDX_W;

  logic [63:0] shifted;
  int          sh;

  always_comb begin
    sh = (lvl_i == '0) ? OFF_W : OFF_W + IDX_W * (int'(lvl_i) - 1);
    shifted = va_i >> sh;
    ent_addr_o = 64'({base_i[PA_W-1:OFF_W], shifted[IDX_W-1:0], {ENT_B{1'b0}}});
  end
endmodule

// File: rtl/gpw_eval.sv
module gpw_eval
  import gpw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 52,
  parameter int LVL_W  = 3
) (
  input  logic [63:0]      ent_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [1:0]       acc_i,
  input  logic [63:0]      va_i,
  output ev_e              kind_o,
  output logic [63:0]      leaf_o,
  output logic [PA_W-1:0]  next_o
);
  logic [2:0]  perm;
  logic        need;
  logic [63:0] mask;
  logic [63:0] frame;
  int          sh;

  always_comb begin
    perm = ent_i[BIT_X:BIT_R];
    unique case (acc_i)
      ACC_WR:  need = perm[BIT_W];
      ACC_EX:  need = perm[BIT_X];
      default: need = perm[BIT_R];
    endcase
    sh     = (lvl_i == '0) ? OFF_W : OFF_W + IDX_W * (int'(lvl_i) - 1);
    mask   = (64'd1 << sh) - 64'd1;
    frame  = 64'(ent_i[PA_W-1:0]) & ~mask;
    leaf_o = frame | (va_i & mask);
    next_o = {ent_i[PA_W-1:OFF_W], {OFF_W{1'b0}}};
    if (perm == 3'b000 || !need)         kind_o = EV_FAULT;
    else if (ent_i[BIT_SP])              kind_o = (int'(lvl_i) == LEVELS) ? EV_FAULT : EV_LEAF;
    else if (lvl_i == LVL_W'(1))         kind_o = EV_LEAF;
    else                                 kind_o = EV_NEXT;
  end
endmodule

// File: rtl/gpw_walker.sv
module gpw_walker
  import gpw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 52,
  parameter int LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xlat_en_i,
  input  logic [63:0]      root_base_i,
  input  logic             req_valid_i,
  input  logic [63:0]      req_addr_i,
  input  logic [1:0]       req_acc_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [63:0]      mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             res_valid_o,
  output logic [63:0]      res_addr_o,
  output logic             res_fault_o,
  output logic [LVL_W-1:0] res_level_o
);
  localparam int VA_W = OFF_W + IDX_W * LEVELS;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WT, S_DONE} st_e;

  st_e              st_q;
  logic             en_q;
  logic [PA_W-1:0]  root_q, base_q;
  logic [63:0]      va_q;
  logic [1:0]       acc_q;
  logic [LVL_W-1:0] lvl_q;
  ev_e              kind;
  logic [63:0]      leaf_pa;
  logic [PA_W-1:0]  next_base;

  gpw_idx #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .LVL_W(LVL_W)) u_idx (
    .base_i(base_q), .va_i(va_q), .lvl_i(lvl_q), .ent_addr_o(mem_addr_o)
  );

  gpw_eval #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .LVL_W(LVL_W)) u_eval (
    .ent_i(mem_rdata_i), .lvl_i(lvl_q), .acc_i(acc_q), .va_i(va_q),
    .kind_o(kind), .leaf_o(leaf_pa), .next_o(next_base)
  );

  // root capture on enable rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      root_q <= '0;
    end else begin
      en_q <= xlat_en_i;
      if (xlat_en_i && !en_q) root_q <= {root_base_i[PA_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      base_q      <= '0;
      va_q        <= '0;
      acc_q       <= '0;
      lvl_q       <= '0;
      res_addr_o  <= '0;
      res_fault_o <= 1'b0;
      res_level_o <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          va_q        <= req_addr_i;
          acc_q       <= req_acc_i;
          res_addr_o  <= req_addr_i;
          res_fault_o <= 1'b0;
          res_level_o <= '0;
          if (!xlat_en_i) begin
            st_q <= S_DONE;
          end else if (|req_addr_i[63:VA_W]) begin
            res_fault_o <= 1'b1;
            st_q        <= S_DONE;
          end else begin
            base_q <= root_q;
            lvl_q  <= LVL_W'(LEVELS);
            st_q   <= S_RD;
          end
        end
        S_RD: st_q <= S_WT;
        S_WT: if (mem_rvalid_i) begin
          unique case (kind)
            EV_NEXT: begin
              base_q <= next_base;
              lvl_q  <= lvl_q - LVL_W'(1);
              st_q   <= S_RD;
            end
            EV_LEAF: begin
              res_addr_o <= leaf_pa;
              st_q       <= S_DONE;
            end
            default: begin
              res_fault_o <= 1'b1;
              res_level_o <= lvl_q;
              st_q        <= S_DONE;
            end
          endcase
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign mem_req_o   = (st_q == S_RD);
  assign res_valid_o = (st_q == S_DONE);
endmodule

// File: rtl/gpw_walker_chk.sv
module gpw_walker_chk #(
  parameter int LEVELS = 4,
  parameter int PA_W   = 52,
  parameter int LVL_W  = $clog2(LEVELS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             busy_o,
  input logic             mem_req_o,
  input logic [63:0]      mem_addr_o,
  input logic             res_valid_o,
  input logic             res_fault_o,
  input logic [LVL_W-1:0] res_level_o
);
  // R10
  res_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  // R11
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R10
  rd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  // R10
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);
  // R1
  rd_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000 && mem_addr_o[63:PA_W] == '0));
  // R10
  ok_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_fault_o) |-> res_level_o == '0);
  // R7
  fault_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o) |-> int'(res_level_o) <= LEVELS);
endmodule

bind gpw_walker gpw_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .res_valid_o(res_valid_o),
  .res_fault_o(res_fault_o), .res_level_o(res_level_o)
);

// File: tb/tb_gpw_walker.sv
`timescale 1ns/1ps
module tb_gpw_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xlat_en_i = 1'b0;
  logic [63:0] root_base_i = '0;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_addr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        busy_o, mem_req_o, res_valid_o, res_fault_o;
  logic [63:0] mem_addr_o, res_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic [2:0]  res_level_o;

  always #2.5 clk_i = ~clk_i;

  gpw_walker dut (.*);

  localparam logic [63:0] PA_MASK = 64'h000F_FFFF_FFFF_F000;

  logic [63:0] mem [logic [63:0]];
  int checks = 0, errors = 0, mem_reads = 0;
  logic [63:0] root_cur = '0;
  logic [63:0] alloc = 64'h0010_0000;

  // memory model, random latency
  logic        pend = 1'b0;
  logic [63:0] pend_a = '0;
  int          pend_c = 0;
  always @(negedge clk_i) begin
    mem_rvalid_i = 1'b0;
    if (mem_req_o) begin
      pend = 1'b1; pend_a = mem_addr_o; pend_c = int'($urandom % 3); mem_reads++;
    end else if (pend) begin
      if (pend_c == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem.exists(pend_a) ? mem[pend_a] : 64'd0;
        pend = 1'b0;
      end else pend_c--;
    end
  end

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ref_walk(input logic [63:0] va, input logic [1:0] acc, input bit en,
                          output logic [63:0] pa, output bit flt, output int lvl, output int nrd);
    logic [63:0] base, e;
    logic [8:0]  idx;
    bit          need;
    pa = va; flt = 0; lvl = 0; nrd = 0;
    if (!en) return;
    if (va[63:48] != 0) begin flt = 1; return; end
    base = root_cur;
    for (int l = 4; l >= 1; l--) begin
      idx = va[(12 + 9 * (l - 1)) +: 9];
      e = rd({12'd0, base[51:12], idx, 3'b000});
      nrd++;
      need = (acc == 2'b01) ? e[1] : (acc == 2'b10) ? e[2] : e[0];
      if (e[2:0] == 0 || !need || (e[7] && l == 4)) begin flt = 1; lvl = l; return; end
      if (e[7] && l == 3) begin pa = {12'd0, e[51:30], va[29:0]}; return; end
      if (e[7] && l == 2) begin pa = {12'd0, e[51:21], va[20:0]}; return; end
      if (l == 1) begin pa = {12'd0, e[51:12], va[11:0]}; return; end
      base = {12'd0, e[51:12], 12'd0};
    end
  endtask

  // table chain for va: super page at sp_lvl, permissions bad_p at bad_lvl
  task automatic build(input logic [63:0] va, input int sp_lvl, input int bad_lvl, input logic [2:0] bad_p);
    logic [63:0] base, a, frame;
    logic [2:0]  p;
    base = root_cur;
    for (int l = 4; l >= 1; l--) begin
      a = {12'd0, base[51:12], va[(12 + 9 * (l - 1)) +: 9], 3'b000};
      p = (l == bad_lvl) ? bad_p : 3'b111;
      frame = {$urandom, $urandom} & PA_MASK;
      if (l == sp_lvl || l == 1) begin
        mem[a] = frame | 64'(p) | ((l == sp_lvl) ? 64'h80 : 64'h0);
        break;
      end
      mem[a] = alloc | 64'(p);
      base = alloc;
      alloc += 64'h1000;
    end
  endtask

  task automatic set_root(input logic [63:0] r);
    @(negedge clk_i); xlat_en_i = 1'b0;
    @(negedge clk_i); root_base_i = r; xlat_en_i = 1'b1;
    @(negedge clk_i);
    root_cur = r & PA_MASK;
  endtask

  task automatic run(input logic [63:0] va, input logic [1:0] acc, input string tag, input bit inject = 0);
    logic [63:0] epa;
    bit          eflt;
    int          elvl, enrd, r0, n;
    ref_walk(va, acc, xlat_en_i, epa, eflt, elvl, enrd);
    r0 = mem_reads;
    @(negedge clk_i); req_valid_i = 1'b1; req_addr_i = va; req_acc_i = acc;
    @(negedge clk_i); req_valid_i = 1'b0;
    if (inject) begin
      chk(busy_o, {tag, " busy"}, 64'(busy_o), 64'd1);
      req_valid_i = 1'b1; req_addr_i = 64'h0000_1234_5678_9000; req_acc_i = 2'b00;
      @(negedge clk_i); req_valid_i = 1'b0;
    end
    n = 0;
    while (!res_valid_o && n < 500) begin @(negedge clk_i); n++; end
    chk(res_valid_o, {tag, " result seen"}, 64'(res_valid_o), 64'd1);
    chk(res_fault_o == eflt, {tag, " fault"}, 64'(res_fault_o), 64'(eflt));
    chk(int'(res_level_o) == elvl, {tag, " level"}, 64'(res_level_o), 64'(elvl));
    if (!eflt) chk(res_addr_o == epa, {tag, " addr"}, res_addr_o, epa);
    chk(mem_reads - r0 == enrd, {tag, " reads"}, 64'(mem_reads - r0), 64'(enrd));
    @(negedge clk_i);
    // R10 single-cycle strobe
    chk(!res_valid_o, {tag, " R10 pulse"}, 64'(res_valid_o), 64'd0);
    if (inject) begin
      n = 0;
      for (int i = 0; i < 12; i++) begin @(negedge clk_i); if (res_valid_o) n++; end
      chk(n == 0, {tag, " R10 dropped request"}, 64'(n), 64'd0);
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] va;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !mem_req_o && !res_valid_o, "reset outputs", {61'd0, busy_o, mem_req_o, res_valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !res_valid_o, "reset idle", {62'd0, busy_o, res_valid_o}, 64'd0);

    set_root(64'h0000_0000_8000_0ABC);
    va = 64'h0000_7A5B_3C2D_1E0F;
    build(va, 0, 0, 3'b111); run(va, 2'b00, "R1 R4 4K read");
    run(va, 2'b01, "R7 4K write");
    run(va, 2'b10, "R7 4K exec");
    va = 64'h0000_1234_5678_9ABC;
    build(va, 3, 0, 3'b111); run(va, 2'b00, "R5 1G page");
    va = 64'h0000_4321_8765_4321;
    build(va, 2, 0, 3'b111); run(va, 2'b10, "R5 2M page");
    va = 64'h0000_5555_AAAA_5555;
    build(va, 4, 0, 3'b111); run(va, 2'b00, "R6 level4 super");
    va = 64'h0000_6666_1111_2222;
    build(va, 0, 3, 3'b101); run(va, 2'b01, "R7 no write L3");
    run(va, 2'b11, "R7 type 11 as read");
    va = 64'h0000_0777_3333_4444;
    build(va, 0, 1, 3'b011); run(va, 2'b10, "R7 no exec L1");
    va = 64'h0000_2468_ACE0_1357;
    build(va, 0, 2, 3'b000); run(va, 2'b00, "R8 not present L2");
    run(64'h8000_0000_0000_1000, 2'b00, "R2 high bits");
    run(64'h0001_0000_0000_0000, 2'b01, "R2 bit48");

    // R3: root change while enabled is ignored
    va = 64'h0000_3030_4040_5050;
    build(va, 0, 0, 3'b111);
    @(negedge clk_i); root_base_i = 64'h0000_0000_9000_0000;
    run(va, 2'b00, "R3 root held");
    set_root(64'h0000_0000_9000_0000);
    build(va, 2, 0, 3'b111); run(va, 2'b00, "R3 root reloaded");

    // R10 request during walk
    va = 64'h0000_0F0F_0F0F_0F0F;
    build(va, 0, 0, 3'b111); run(va, 2'b00, "R10 busy", 1'b1);

    // R9 bypass
    @(negedge clk_i); xlat_en_i = 1'b0;
    run(64'hDEAD_BEEF_CAFE_F00D, 2'b10, "R9 bypass");
    run(64'h0000_0000_0000_0000, 2'b01, "R9 bypass zero");
    set_root(64'h0000_0000_8000_0000);

    // random walks (R11 latency varies)
    for (int i = 0; i < 80; i++) begin
      int sp, bl;
      logic [2:0] bp;
      va = {16'd0, 16'($urandom), $urandom};
      if ($urandom % 16 == 0) va[63:48] = 16'($urandom | 1);
      sp = int'($urandom % 5); if (sp == 1) sp = 0;
      bl = ($urandom % 4 == 0) ? int'($urandom % 4) + 1 : 0;
      bp = 3'($urandom);
      if (va[63:48] == 0) build(va, sp, bl, bp);
      run(va, 2'($urandom), "R11 random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule